// File: doc/BRIEF.md
# Dual-Channel Double-Buffered Serial DAC Controller

This block is the digital front end of a two-channel digital-to-analog converter. A host shifts 24-bit words into a serial shift register. The shift clock is the OR of the serial clock pin and the active-low chip select, so either pin can clock the data. A word holds a channel-select flag, a quick-load flag and a 16-bit code.

While the load strobe is held low, the addressed holding register copies the code from the shift register. With quick-load set, both holding registers copy it. A rising edge on the update strobe then copies both holding registers into the two output code registers in the same cycle. A rising edge on the clear pin forces all four code registers to mid-scale or to zero, as a select pin chooses. The last shift-register stage drives a serial output, so several blocks can be chained.

All pins are asynchronous to the system clock. Each pin passes through a two-flop synchronizer, and edges are found by comparing the synchronized level with its previous sample. A pin change therefore reaches the registers on the third system clock edge after it is first sampled. A synchronous active-high reset stands in for power-on.

Top module: `dacpair_serial_ctrl`

## Requirements
- R1: The word is 24 bits, sent first bit first, and the first bit ends up in bit 23. Bit 23 selects the channel (0 = channel A, 1 = channel B). Bit 21 is the quick-load flag. Bits 15..0 are the code, sent MSB first. Bits 22 and 20..16 have no effect.
- R2: The shift register moves one place and takes the synchronized data pin on every rising edge of (ser_clk OR ser_cs_n). Clocking with ser_cs_n while ser_clk is held low gives the same result as clocking with ser_clk while ser_cs_n is low.
- R3: If ser_cs_n rises while ser_clk is low, the shift register takes one extra bit. That bit is the data pin's value at that moment.
- R4: While ld_n is low, the holding registers load bits 15..0 of the shift register. With bit 21 set, both registers load. With bit 21 clear, only the register addressed by bit 23 loads, and the other keeps its value.
- R5: The load is level-sensitive. Bits shifted while ld_n is low pass into the addressed holding register(s) as they move through the shift register.
- R6: A rising edge of dac_upd copies both holding registers into dac_code_a and dac_code_b in the same cycle. At all other times the output codes hold, including while the holding registers are being written.
- R7: A rising edge of clr_pulse sets both holding registers and both output codes to 16'h8000 when clr_mid_sel is high, and to 16'h0000 when it is low.
- R8: A clear edge leaves the shift register unchanged, which shows at ser_dout.
- R9: ser_dout always shows bit 23 of the shift register, so a word comes out of it as the next word shifts in.
- R10: After reset the shift register is all zeros (ser_dout = 0), and all code registers hold 16'h8000 or 16'h0000 as clr_mid_sel directs. Pin edges take effect no sooner than the fourth clock after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than any pin activity |
| rst | input | 1 | Synchronous active-high reset (power-on) |
| ser_clk | input | 1 | Serial clock pin, asynchronous |
| ser_cs_n | input | 1 | Active-low chip select, ORed with ser_clk to form the shift clock |
| ser_din | input | 1 | Serial data in |
| ld_n | input | 1 | Active-low level load of the holding registers |
| dac_upd | input | 1 | Rising edge copies holding registers to output codes |
| clr_pulse | input | 1 | Rising edge clears all code registers |
| clr_mid_sel | input | 1 | Clear value select: 1 = mid-scale, 0 = zero |
| ser_dout | output | 1 | Serial data out (last shift stage) |
| dac_code_a | output | 16 | Output code of channel A |
| dac_code_b | output | 16 | Output code of channel B |

## Verification
The assertions assume the pins are much slower than the clock. Each pin level must last at least two clock cycles, so that no edge is lost in the synchronizers. clr_mid_sel must be steady around a clear edge. The stimulus keeps every pin level for at least four cycles and changes clr_mid_sel several cycles before clr_pulse rises. It keeps ld_n high across clears and switches between ser_clk and ser_cs_n clocking only while both are high. The one exception is the deliberate ser_cs_n rise with ser_clk low that exercises the extra shift.

// File: rtl/dacpair_pkg.sv
package dacpair_pkg;
  // bit positions inside the synchronized pin vector
  localparam int PIN_W     = 7;
  localparam int P_SCK     = 0;
  localparam int P_CSN     = 1;
  localparam int P_SDI     = 2;
  localparam int P_LDN     = 3;
  localparam int P_UPD     = 4;
  localparam int P_CLR     = 5;
  localparam int P_CLRSEL  = 6;
  localparam int NUM_CH    = 2;
endpackage

// File: rtl/dacpair_pin_sync.sv
module dacpair_pin_sync #(
  parameter int W      = 7,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] lvl,
  output logic [W-1:0] prv,
  output logic         ready
);
  localparam int FILL  = STAGES + 1;
  localparam int CNT_W = $clog2(FILL + 1);

  logic [W-1:0]     pipe_q [STAGES];
  logic [W-1:0]     prv_q;
  logic [CNT_W-1:0] fill_q;

  always_ff @(posedge clk) begin
    if (rst) pipe_q[0] <= '0;
    else     pipe_q[0] <= pin_in;
  end

  genvar g;
  generate
    for (g = 1; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) pipe_q[g] <= '0;
        else     pipe_q[g] <= pipe_q[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      prv_q  <= '0;
      fill_q <= '0;
    end else begin
      prv_q <= pipe_q[STAGES-1];
      if (fill_q != CNT_W'(FILL)) fill_q <= fill_q + 1'b1;
    end
  end

  assign lvl   = pipe_q[STAGES-1];
  assign prv   = prv_q;
  assign ready = (fill_q == CNT_W'(FILL));

  // R10: once edges are trusted they stay trusted until reset
  a_r10_ready_sticky: assert property (@(posedge clk) disable iff (rst)
    ready |=> ready);
endmodule

// File: rtl/dacpair_shifter.sv
module dacpair_shifter #(
  parameter int FRAME_W = 24
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               step,
  input  logic               din,
  output logic [FRAME_W-1:0] frame,
  output logic               dout
);
  logic [FRAME_W-1:0] sr_q;

  always_ff @(posedge clk) begin
    if (rst)       sr_q <= '0;
    else if (step) sr_q <= {sr_q[FRAME_W-2:0], din};
  end

  assign frame = sr_q;
  assign dout  = sr_q[FRAME_W-1];
endmodule

// File: rtl/dacpair_channel.sv
module dacpair_channel #(
  parameter int CODE_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] rst_code,
  input  logic              clr,
  input  logic [CODE_W-1:0] clr_code,
  input  logic              wr_en,
  input  logic [CODE_W-1:0] wr_code,
  input  logic              upd,
  output logic [CODE_W-1:0] hold_q,
  output logic [CODE_W-1:0] out_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= rst_code;
      out_q  <= rst_code;
    end else if (clr) begin
      hold_q <= clr_code;
      out_q  <= clr_code;
    end else begin
      if (wr_en) hold_q <= wr_code;
      if (upd)   out_q  <= hold_q;
    end
  end
endmodule

// File: rtl/dacpair_serial_ctrl.sv
module dacpair_serial_ctrl
  import dacpair_pkg::*;
#(
  parameter int FRAME_W     = 24,
  parameter int CODE_W      = 16,
  parameter int SEL_POS     = 23,
  parameter int QUICK_POS   = 21,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_clk,
  input  logic              ser_cs_n,
  input  logic              ser_din,
  input  logic              ld_n,
  input  logic              dac_upd,
  input  logic              clr_pulse,
  input  logic              clr_mid_sel,
  output logic              ser_dout,
  output logic [CODE_W-1:0] dac_code_a,
  output logic [CODE_W-1:0] dac_code_b
);
  localparam logic [CODE_W-1:0] MID_CODE = {1'b1, {(CODE_W-1){1'b0}}};

  logic [PIN_W-1:0]   pins, lvl, prv;
  logic               ready;
  logic               sh_rise, upd_rise, clr_rise, load_act;
  logic [FRAME_W-1:0] frame;
  logic [CODE_W-1:0]  rst_code, clr_code;
  logic [CODE_W-1:0]  hold_q [NUM_CH];
  logic [CODE_W-1:0]  out_q  [NUM_CH];
  logic [NUM_CH-1:0]  wr_en;
  logic               unused_bits;

  always_comb begin
    pins           = '0;
    pins[P_SCK]    = ser_clk;
    pins[P_CSN]    = ser_cs_n;
    pins[P_SDI]    = ser_din;
    pins[P_LDN]    = ld_n;
    pins[P_UPD]    = dac_upd;
    pins[P_CLR]    = clr_pulse;
    pins[P_CLRSEL] = clr_mid_sel;
  end

  dacpair_pin_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .pin_in(pins), .lvl(lvl), .prv(prv), .ready(ready)
  );

  // shift clock is the OR of clock and chip select, edge found after sync
  assign sh_rise  = ready & (lvl[P_SCK] | lvl[P_CSN]) & ~(prv[P_SCK] | prv[P_CSN]);
  assign upd_rise = ready & lvl[P_UPD] & ~prv[P_UPD];
  assign clr_rise = ready & lvl[P_CLR] & ~prv[P_CLR];
  assign load_act = ready & ~lvl[P_LDN];

  assign rst_code = clr_mid_sel     ? MID_CODE : '0;
  assign clr_code = lvl[P_CLRSEL]   ? MID_CODE : '0;

  dacpair_shifter #(.FRAME_W(FRAME_W)) u_shift (
    .clk(clk), .rst(rst), .step(sh_rise), .din(lvl[P_SDI]),
    .frame(frame), .dout(ser_dout)
  );

  genvar ch;
  generate
    for (ch = 0; ch < NUM_CH; ch++) begin : g_ch
      assign wr_en[ch] = load_act & (frame[QUICK_POS] | (frame[SEL_POS] == 1'(ch)));
      dacpair_channel #(.CODE_W(CODE_W)) u_chan (
        .clk(clk), .rst(rst), .rst_code(rst_code),
        .clr(clr_rise), .clr_code(clr_code),
        .wr_en(wr_en[ch]), .wr_code(frame[CODE_W-1:0]),
        .upd(upd_rise), .hold_q(hold_q[ch]), .out_q(out_q[ch])
      );
    end
  endgenerate

  assign dac_code_a  = out_q[0];
  assign dac_code_b  = out_q[1];
  assign unused_bits = ^{frame, prv};

  // R2 R8: the shift register moves only on a shift-clock rising edge
  a_r8_frame_still: assert property (@(posedge clk) disable iff (rst)
    !sh_rise |=> $stable(frame));
  // R6: outputs hold unless an update or clear edge was seen
  a_r6_out_hold: assert property (@(posedge clk) disable iff (rst)
    (!upd_rise && !clr_rise) |=> ($stable(dac_code_a) && $stable(dac_code_b)));
  // R6: update copies the holding registers together
  a_r6_out_copy: assert property (@(posedge clk) disable iff (rst)
    (upd_rise && !clr_rise) |=> (dac_code_a == $past(hold_q[0]) && dac_code_b == $past(hold_q[1])));
  // R4: quick load writes both holding registers
  a_r4_quick_both: assert property (@(posedge clk) disable iff (rst)
    (load_act && frame[QUICK_POS] && !clr_rise) |=>
      (hold_q[0] == $past(frame[CODE_W-1:0]) && hold_q[1] == $past(frame[CODE_W-1:0])));
  // R4: addressed load to channel A leaves channel B alone
  a_r4_other_kept: assert property (@(posedge clk) disable iff (rst)
    (load_act && !frame[QUICK_POS] && !frame[SEL_POS] && !clr_rise) |=> $stable(hold_q[1]));
  // R7: mid-scale clear reaches all four registers
  a_r7_clear_mid: assert property (@(posedge clk) disable iff (rst)
    (clr_rise && lvl[P_CLRSEL]) |=> (hold_q[0] == MID_CODE && hold_q[1] == MID_CODE &&
                                     dac_code_a == MID_CODE && dac_code_b == MID_CODE));
  // R7: zero clear reaches all four registers
  a_r7_clear_zero: assert property (@(posedge clk) disable iff (rst)
    (clr_rise && !lvl[P_CLRSEL]) |=> (hold_q[0] == '0 && hold_q[1] == '0 &&
                                      dac_code_a == '0 && dac_code_b == '0));
endmodule

// File: tb/dacpair_serial_ctrl_bench.sv
module dacpair_serial_ctrl_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ser_clk = 1'b1, ser_cs_n = 1'b1, ser_din = 1'b0, ld_n = 1'b1;
  logic dac_upd = 1'b0, clr_pulse = 1'b0, clr_mid_sel = 1'b1;
  logic ser_dout;
  logic [15:0] dac_code_a, dac_code_b;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  string phase = "R10";

  always #2 clk = ~clk;

  dacpair_serial_ctrl u_dacpair_serial_ctrl (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_cs_n(ser_cs_n), .ser_din(ser_din),
    .ld_n(ld_n), .dac_upd(dac_upd), .clr_pulse(clr_pulse), .clr_mid_sel(clr_mid_sel),
    .ser_dout(ser_dout), .dac_code_a(dac_code_a), .dac_code_b(dac_code_b)
  );

  // behavioural reference: pin history queue, then the word rules
  logic [6:0] pin_hist [$];
  logic [23:0] m_sr;
  logic [15:0] m_ha, m_hb, m_oa, m_ob;
  int          m_fill;

  function automatic logic [6:0] pin_now();
    return {clr_mid_sel, clr_pulse, dac_upd, ld_n, ser_din, ser_cs_n, ser_clk};
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      pin_hist = '{7'd0, 7'd0, 7'd0};
      m_fill = 0;
      m_sr = '0;
      m_ha = clr_mid_sel ? 16'h8000 : 16'h0000;
      m_hb = m_ha; m_oa = m_ha; m_ob = m_ha;
    end else begin
      logic [6:0] cur, old;
      logic [23:0] w;
      logic ok, shr, updr, clrr, lda;
      cur = pin_hist[1];
      old = pin_hist[2];
      ok   = (m_fill == 3);
      shr  = ok && (cur[0] | cur[1]) && !(old[0] | old[1]);
      updr = ok && cur[4] && !old[4];
      clrr = ok && cur[5] && !old[5];
      lda  = ok && !cur[3];
      w = m_sr;
      if (shr) m_sr = {m_sr[22:0], cur[2]};
      if (clrr) begin
        m_ha = cur[6] ? 16'h8000 : 16'h0000;
        m_hb = m_ha; m_oa = m_ha; m_ob = m_ha;
      end else begin
        if (updr) begin m_oa = m_ha; m_ob = m_hb; end
        if (lda && (w[21] || !w[23])) m_ha = w[15:0];
        if (lda && (w[21] ||  w[23])) m_hb = w[15:0];
      end
      void'(pin_hist.pop_back());
      pin_hist.push_front(pin_now());
      if (m_fill < 3) m_fill++;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (!rst) begin
      chk({phase, " model code_a"}, {16'h0, dac_code_a}, {16'h0, m_oa});
      chk({phase, " model code_b"}, {16'h0, dac_code_b}, {16'h0, m_ob});
      chk({phase, " model sdo"}, {31'h0, ser_dout}, {31'h0, m_sr[23]});
    end
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  // cs_clk=1: ser_clk held low, ser_cs_n is the clock; extra=1: finish with cs rise while clk low
  task automatic send(logic [23:0] w, bit cs_clk, bit extra);
    if (cs_clk) begin
      ser_clk = 1'b0; wait_n(4);
      for (int i = 23; i >= 0; i--) begin
        ser_cs_n = 1'b0; ser_din = w[i]; wait_n(4);
        ser_cs_n = 1'b1; wait_n(4);
      end
      ser_clk = 1'b1; wait_n(4);
    end else begin
      ser_cs_n = 1'b0; wait_n(4);
      for (int i = 23; i >= 0; i--) begin
        ser_clk = 1'b0; ser_din = w[i]; wait_n(4);
        ser_clk = 1'b1; wait_n(4);
      end
      if (extra) begin
        ser_clk = 1'b0; ser_din = 1'b1; wait_n(4);
        ser_cs_n = 1'b1; wait_n(4);
        ser_clk = 1'b1; wait_n(4);
      end else begin
        ser_cs_n = 1'b1; wait_n(4);
      end
    end
  endtask

  task automatic load_pulse();
    ld_n = 1'b0; wait_n(6); ld_n = 1'b1; wait_n(6);
  endtask

  task automatic upd_pulse();
    dac_upd = 1'b1; wait_n(6); dac_upd = 1'b0; wait_n(6);
  endtask

  task automatic clear_pulse(logic sel);
    clr_mid_sel = sel; wait_n(4);
    clr_pulse = 1'b1; wait_n(6); clr_pulse = 1'b0; wait_n(6);
  endtask

  initial begin
    wait_n(5);
    rst = 1'b0;
    wait_n(1);
    chk("R10 reset code_a", {16'h0, dac_code_a}, 32'h8000);
    chk("R10 reset code_b", {16'h0, dac_code_b}, 32'h8000);
    chk("R10 reset sdo", {31'h0, ser_dout}, 32'h0);
    wait_n(6);

    phase = "R1";
    send(24'h001234, 1'b0, 1'b0);
    load_pulse();
    chk("R6 outputs hold after load", {16'h0, dac_code_a}, 32'h8000);
    upd_pulse();
    chk("R1 channel A code", {16'h0, dac_code_a}, 32'h1234);
    chk("R4 channel B untouched", {16'h0, dac_code_b}, 32'h8000);
    chk("R9 sdo shows bit 23 (0)", {31'h0, ser_dout}, 32'h0);

    phase = "R1";
    send(24'h9FABCD, 1'b0, 1'b0);
    load_pulse();
    upd_pulse();
    chk("R1 channel B code, unused bits set", {16'h0, dac_code_b}, 32'hABCD);
    chk("R4 channel A untouched", {16'h0, dac_code_a}, 32'h1234);
    chk("R9 sdo shows bit 23 (1)", {31'h0, ser_dout}, 32'h1);

    phase = "R4";
    send(24'hA05A5A, 1'b0, 1'b0);
    load_pulse();
    upd_pulse();
    chk("R4 quick load code_a", {16'h0, dac_code_a}, 32'h5A5A);
    chk("R4 quick load code_b", {16'h0, dac_code_b}, 32'h5A5A);

    phase = "R2";
    send(24'h000F0F, 1'b1, 1'b0);
    load_pulse();
    upd_pulse();
    chk("R2 chip-select clocking code_a", {16'h0, dac_code_a}, 32'h0F0F);
    chk("R2 chip-select clocking code_b", {16'h0, dac_code_b}, 32'h5A5A);

    phase = "R3";
    send(24'h000001, 1'b0, 1'b1);
    load_pulse();
    upd_pulse();
    chk("R3 extra shift code_a", {16'h0, dac_code_a}, 32'h0003);
    chk("R3 extra shift code_b", {16'h0, dac_code_b}, 32'h5A5A);

    phase = "R5";
    ld_n = 1'b0; wait_n(4);
    send(24'h807E81, 1'b0, 1'b0);
    ld_n = 1'b1; wait_n(6);
    upd_pulse();
    chk("R5 level load ends on final code_b", {16'h0, dac_code_b}, 32'h7E81);

    phase = "R7";
    clear_pulse(1'b0);
    chk("R7 zero clear code_a", {16'h0, dac_code_a}, 32'h0);
    chk("R7 zero clear code_b", {16'h0, dac_code_b}, 32'h0);
    chk("R8 sdo kept across clear", {31'h0, ser_dout}, 32'h1);
    upd_pulse();
    chk("R7 holding registers cleared too", {16'h0, dac_code_b}, 32'h0);

    clear_pulse(1'b1);
    upd_pulse();
    chk("R7 mid clear code_a", {16'h0, dac_code_a}, 32'h8000);
    chk("R7 mid clear code_b", {16'h0, dac_code_b}, 32'h8000);

    phase = "R8";
    send(24'h000000, 1'b0, 1'b0);
    chk("R9 chained word shifted out, sdo", {31'h0, ser_dout}, 32'h0);
    wait_n(4);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule